// File: doc/BRIEF.md
# DRAM Bank-Open Command Issuer

This block takes one host read or write request at a time and turns it into a legal sequence of commands on a DDR3-style command/address bus. Each request carries a flat address, a read/write flag, a burst-chop flag and an auto-precharge flag. The block splits the address into row, bank and column fields and keeps a table of which row is open in each of eight banks. It then issues only the commands that access needs. A request to a closed bank gets an activate followed by the column command. A request to the open row goes straight to the column command. A request to a different row in an open bank gets a precharge first, then an activate, then the column command.

The controller is a five-state machine:
- **IDLE** waits for a request, with ready high and NOP on the bus.
- **PRECH** issues a single-bank precharge.
- **ACTV** issues the activate.
- **HOLD** drives NOP until the programmed activate-to-column spacing is used up.
- **COLM** issues the read or write and then returns to IDLE.

The transitions out of IDLE are:
- IDLE→ACTV when the bank is closed.
- IDLE→COLM on a row hit.
- IDLE→PRECH on a row miss.

The remaining transitions are:
- PRECH→ACTV always.
- ACTV→COLM when the spacing is one cycle or less.
- ACTV→HOLD otherwise.
- HOLD→COLM on the last waiting cycle.
- COLM→IDLE always.

Top module: `bank_cmd_issuer`

## Requirements
- R1: The request address is split as row = `req_addr[26:13]`, bank = `req_addr[12:10]`, column = `req_addr[9:0]`. An activate drives the row on `cmd_a` and the bank on `cmd_ba`. A column command drives the column on `cmd_a[9:0]` and the bank on `cmd_ba`.
- R2: The command encodings on {cs_n, ras_n, cas_n, we_n} are NOP 0111, activate 0011, read 0101, write 0100 and precharge 0010.
- R3: `req_ready` is high only in IDLE. It drops in the cycle after a request is accepted. It stays low until the column command has been issued, and it is high again in the following cycle.
- R4: A request to a closed bank issues an activate in the first cycle after acceptance, and later issues the column command.
- R5: The column command follows its activate after exactly max(`trcd_cycles`, 1) cycles, with NOP in between.
- R6: A request to the row already open in its bank issues the column command in the first cycle after acceptance, with no activate.
- R7: A request to an open bank holding a different row issues a precharge to that bank, with all of `cmd_a` zero, in the first cycle after acceptance. The activate follows in the next cycle.
- R8: `cmd_a[10]` of a column command equals the request's auto-precharge flag. After a column command with this bit set, the bank counts as closed, so the next access to it starts with an activate and has no precharge.
- R9: With `otf_en` high, `cmd_a[12]` of a column command is 1 for a full burst of eight and 0 for a chopped burst of four (`req_chop` high). With `otf_en` low, `cmd_a[12]` is 0. All other address bits above the column field are 0.
- R10: After reset all banks are closed, the bus carries NOP and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 27 | Flat address {row, bank, column} |
| req_chop | input | 1 | Request a chopped burst of four |
| req_autopre | input | 1 | Close the bank after the burst |
| otf_en | input | 1 | On-the-fly burst length selection enabled |
| trcd_cycles | input | 5 | Activate-to-column spacing in cycles |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_ba | output | 3 | Bank address |
| cmd_a | output | 14 | Row/column address lines |

## Verification
The assertions assume that `trcd_cycles` and `otf_en` stay constant while a request is in flight. They also assume that the block is the only issuer on the bus, so that a shadow bank map built from observed commands matches the state of the device. The bench changes `trcd_cycles` and `otf_en` only while `req_ready` is high and no request is pending. It raises `req_valid` only at a falling edge while the block is idle, and drops it after the accepting edge.

// File: rtl/bci_pkg.sv
package bci_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRECH,
        ST_ACTV,
        ST_HOLD,
        ST_COLM
    } bci_state_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } bci_cmd_t;

    localparam bci_cmd_t CMD_NOP = 4'b0111;
    localparam bci_cmd_t CMD_ACT = 4'b0011;
    localparam bci_cmd_t CMD_RD  = 4'b0101;
    localparam bci_cmd_t CMD_WR  = 4'b0100;
    localparam bci_cmd_t CMD_PRE = 4'b0010;

endpackage

// File: rtl/bci_addr_split.sv
module bci_addr_split #(
    parameter int BANK_W = 3,
    parameter int ROW_W  = 14,
    parameter int COL_W  = 10,
    localparam int ADDR_W = ROW_W + BANK_W + COL_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [ROW_W-1:0]  row,
    output logic [BANK_W-1:0] bank,
    output logic [COL_W-1:0]  col
);
    // Row in the top bits, bank in the middle, column at the bottom.
    assign row  = addr[ADDR_W-1 -: ROW_W];
    assign bank = addr[COL_W +: BANK_W];
    assign col  = addr[COL_W-1:0];
endmodule

// File: rtl/bci_row_table.sv
module bci_row_table #(
    parameter int BANK_W = 3,
    parameter int ROW_W  = 14,
    localparam int NBANK = 1 << BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] rd_bank,
    output logic              rd_open,
    output logic [ROW_W-1:0]  rd_row,
    input  logic              set_en,
    input  logic [BANK_W-1:0] set_bank,
    input  logic [ROW_W-1:0]  set_row,
    input  logic              clr_en,
    input  logic [BANK_W-1:0] clr_bank
);
    logic [NBANK-1:0] open_q;
    logic [ROW_W-1:0] row_q [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q[b] <= 1'b0;
            end else if (clr_en && clr_bank == BANK_W'(b)) begin
                open_q[b] <= 1'b0;
            end else if (set_en && set_bank == BANK_W'(b)) begin
                open_q[b] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                row_q[b] <= '0;
            end else if (set_en && set_bank == BANK_W'(b)) begin
                row_q[b] <= set_row;
            end
        end
    end

    assign rd_open = open_q[rd_bank];
    assign rd_row  = row_q[rd_bank];
endmodule

// File: rtl/bci_gap_timer.sv
module bci_gap_timer #(
    parameter int TRCD_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [TRCD_W-1:0] span,
    output logic              short_gap,
    output logic              last
);
    logic [TRCD_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= (span == '0) ? '0 : span - TRCD_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - TRCD_W'(1);
        end
    end

    // A span of 0 or 1 lets the column command follow the activate directly.
    assign short_gap = (span <= TRCD_W'(1));
    assign last      = (cnt_q == TRCD_W'(1));
endmodule

// File: rtl/bank_cmd_issuer.sv
module bank_cmd_issuer
    import bci_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int ROW_W  = 14,
    parameter int COL_W  = 10,
    parameter int TRCD_W = 5,
    localparam int ADDR_W = ROW_W + BANK_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_chop,
    input  logic              req_autopre,
    input  logic              otf_en,
    input  logic [TRCD_W-1:0] trcd_cycles,
    output logic              cmd_cs_n,
    output logic              cmd_ras_n,
    output logic              cmd_cas_n,
    output logic              cmd_we_n,
    output logic [BANK_W-1:0] cmd_ba,
    output logic [ROW_W-1:0]  cmd_a
);
    localparam int AP_BIT = 10;
    localparam int BC_BIT = 12;

    bci_state_t st_q, st_d;

    logic [ROW_W-1:0]  in_row;
    logic [BANK_W-1:0] in_bank;
    logic [COL_W-1:0]  in_col;

    logic [ROW_W-1:0]  row_q;
    logic [BANK_W-1:0] bank_q;
    logic [COL_W-1:0]  col_q;
    logic              wr_q, chop_q, ap_q;

    logic              look_open;
    logic [ROW_W-1:0]  look_row;
    logic              accept;
    logic              clr_en;
    logic              gap_short, gap_last;

    bci_cmd_t          cmd_o;
    logic [BANK_W-1:0] ba_o;
    logic [ROW_W-1:0]  a_o;

    assign accept    = req_valid && (st_q == ST_IDLE);
    assign req_ready = (st_q == ST_IDLE);
    assign clr_en    = (st_q == ST_PRECH) || ((st_q == ST_COLM) && ap_q);

    bci_addr_split #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_split (
        .addr (req_addr),
        .row  (in_row),
        .bank (in_bank),
        .col  (in_col)
    );

    bci_row_table #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_bank  (in_bank),
        .rd_open  (look_open),
        .rd_row   (look_row),
        .set_en   (st_q == ST_ACTV),
        .set_bank (bank_q),
        .set_row  (row_q),
        .clr_en   (clr_en),
        .clr_bank (bank_q)
    );

    bci_gap_timer #(.TRCD_W(TRCD_W)) u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (st_q == ST_ACTV),
        .span      (trcd_cycles),
        .short_gap (gap_short),
        .last      (gap_last)
    );

    // Request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q  <= '0;
            bank_q <= '0;
            col_q  <= '0;
            wr_q   <= 1'b0;
            chop_q <= 1'b0;
            ap_q   <= 1'b0;
        end else if (accept) begin
            row_q  <= in_row;
            bank_q <= in_bank;
            col_q  <= in_col;
            wr_q   <= req_write;
            chop_q <= req_chop;
            ap_q   <= req_autopre;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (accept) begin
                    if (!look_open) begin
                        st_d = ST_ACTV;
                    end else if (look_row == in_row) begin
                        st_d = ST_COLM;
                    end else begin
                        st_d = ST_PRECH;
                    end
                end
            end
            ST_PRECH: st_d = ST_ACTV;
            ST_ACTV:  st_d = gap_short ? ST_COLM : ST_HOLD;
            ST_HOLD:  st_d = gap_last ? ST_COLM : ST_HOLD;
            ST_COLM:  st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // Bus outputs
    always_comb begin
        cmd_o = CMD_NOP;
        ba_o  = '0;
        a_o   = '0;
        unique case (st_q)
            ST_PRECH: begin
                cmd_o = CMD_PRE;
                ba_o  = bank_q;
            end
            ST_ACTV: begin
                cmd_o = CMD_ACT;
                ba_o  = bank_q;
                a_o   = row_q;
            end
            ST_COLM: begin
                cmd_o              = wr_q ? CMD_WR : CMD_RD;
                ba_o               = bank_q;
                a_o[COL_W-1:0]     = col_q;
                a_o[AP_BIT]        = ap_q;
                a_o[BC_BIT]        = otf_en & ~chop_q;
            end
            default: begin
                cmd_o = CMD_NOP;
            end
        endcase
    end

    assign cmd_cs_n  = cmd_o.cs_n;
    assign cmd_ras_n = cmd_o.ras_n;
    assign cmd_cas_n = cmd_o.cas_n;
    assign cmd_we_n  = cmd_o.we_n;
    assign cmd_ba    = ba_o;
    assign cmd_a     = a_o;
endmodule

// File: rtl/bci_checker.sv
module bci_checker #(
    parameter int BANK_W = 3,
    parameter int ROW_W  = 14,
    parameter int TRCD_W = 5,
    localparam int NBANK = 1 << BANK_W,
    localparam int CNT_W = TRCD_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              otf_en,
    input logic [TRCD_W-1:0] trcd_cycles,
    input logic              cmd_cs_n,
    input logic              cmd_ras_n,
    input logic              cmd_cas_n,
    input logic              cmd_we_n,
    input logic [BANK_W-1:0] cmd_ba,
    input logic [ROW_W-1:0]  cmd_a
);
    logic [3:0] cmd;
    logic       is_act, is_pre, is_col;
    logic [NBANK-1:0] sh_open;
    logic [CNT_W-1:0] since [NBANK];
    logic [CNT_W-1:0] need;

    assign cmd    = {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};
    assign is_act = (cmd == 4'b0011);
    assign is_pre = (cmd == 4'b0010);
    assign is_col = (cmd == 4'b0101) || (cmd == 4'b0100);
    assign need   = (trcd_cycles == '0) ? CNT_W'(1) : CNT_W'(trcd_cycles);

    // Shadow bank map and per-bank activate age, built only from the bus.
    for (genvar b = 0; b < NBANK; b++) begin : g_sh
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh_open[b] <= 1'b0;
                since[b]   <= '1;
            end else begin
                if (cmd_ba == BANK_W'(b) && is_act) begin
                    sh_open[b] <= 1'b1;
                end else if (cmd_ba == BANK_W'(b) && (is_pre || (is_col && cmd_a[10]))) begin
                    sh_open[b] <= 1'b0;
                end
                if (cmd_ba == BANK_W'(b) && is_act) begin
                    since[b] <= CNT_W'(1);
                end else if (since[b] != '1) begin
                    since[b] <= since[b] + CNT_W'(1);
                end
            end
        end
    end

    a_r10_nop_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (cmd == 4'b0111));

    a_r3_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r4_col_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
        is_col |-> sh_open[cmd_ba]);

    a_r7_act_needs_closed: assert property (@(posedge clk) disable iff (!rst_n)
        is_act |-> !sh_open[cmd_ba]);

    a_r7_pre_single_open: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> (!cmd_a[10] && sh_open[cmd_ba]));

    a_r5_trcd_gap: assert property (@(posedge clk) disable iff (!rst_n)
        is_col |-> (since[cmd_ba] >= need));

    a_r9_a12_low_without_otf: assert property (@(posedge clk) disable iff (!rst_n)
        (is_col && !otf_en) |-> !cmd_a[12]);
endmodule

bind bank_cmd_issuer bci_checker #(
    .BANK_W (BANK_W),
    .ROW_W  (ROW_W),
    .TRCD_W (TRCD_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .otf_en      (otf_en),
    .trcd_cycles (trcd_cycles),
    .cmd_cs_n    (cmd_cs_n),
    .cmd_ras_n   (cmd_ras_n),
    .cmd_cas_n   (cmd_cas_n),
    .cmd_we_n    (cmd_we_n),
    .cmd_ba      (cmd_ba),
    .cmd_a       (cmd_a)
);

// File: tb/bank_cmd_issuer_bench.sv
module bank_cmd_issuer_bench;
    localparam int BANK_W = 3;
    localparam int ROW_W  = 14;
    localparam int COL_W  = 10;
    localparam int TRCD_W = 5;
    localparam int ADDR_W = ROW_W + BANK_W + COL_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic req_chop = 1'b0;
    logic req_autopre = 1'b0;
    logic otf_en = 1'b0;
    logic [TRCD_W-1:0] trcd_cycles = 5'd11;
    logic cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n;
    logic [BANK_W-1:0] cmd_ba;
    logic [ROW_W-1:0]  cmd_a;

    int tests = 0;
    int fails = 0;

    logic       m_open [8];
    logic [13:0] m_row [8];

    logic [3:0]  exp_cmd [64];
    logic [2:0]  exp_ba  [64];
    logic [13:0] exp_a   [64];

    always #5 clk = ~clk;

    bank_cmd_issuer u_bank_cmd_issuer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_chop(req_chop),
        .req_autopre(req_autopre), .otf_en(otf_en), .trcd_cycles(trcd_cycles),
        .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n),
        .cmd_we_n(cmd_we_n), .cmd_ba(cmd_ba), .cmd_a(cmd_a)
    );

    function automatic logic [3:0] bus_cmd();
        return {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};
    endfunction

    // One request; the whole command sequence counts as one check.
    task automatic run_req(input bit wr, input int b, input logic [13:0] r,
                           input logic [9:0] c, input bit ch, input bit ap,
                           input string tag);
        int n;
        int gap;
        int bad;
        logic [13:0] cola;
        gap = (trcd_cycles == 0) ? 1 : int'(trcd_cycles);
        cola = {1'b0, otf_en & ~ch, 1'b0, ap, c};
        n = 0;
        if (!(m_open[b] && m_row[b] == r)) begin
            if (m_open[b]) begin
                exp_cmd[n] = 4'b0010; exp_ba[n] = 3'(b); exp_a[n] = '0; n++;
            end
            exp_cmd[n] = 4'b0011; exp_ba[n] = 3'(b); exp_a[n] = r; n++;
            for (int k = 1; k < gap; k++) begin
                exp_cmd[n] = 4'b0111; exp_ba[n] = '0; exp_a[n] = '0; n++;
            end
        end
        exp_cmd[n] = wr ? 4'b0100 : 4'b0101; exp_ba[n] = 3'(b); exp_a[n] = cola; n++;
        m_open[b] = !ap;
        m_row[b]  = r;

        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_chop = ch; req_autopre = ap;
        req_addr = {r, 3'(b), c};
        @(negedge clk);
        req_valid = 1'b0;
        bad = 0;
        for (int k = 0; k < n; k++) begin
            if (bad == 0 && (bus_cmd() != exp_cmd[k] || cmd_ba != exp_ba[k] ||
                             cmd_a != exp_a[k] || req_ready !== 1'b0)) begin
                bad = 1;
                $display("FAIL %s step %0d: cmd=%b ba=%0d a=%h rdy=%b expected cmd=%b ba=%0d a=%h rdy=0",
                         tag, k, bus_cmd(), cmd_ba, cmd_a, req_ready,
                         exp_cmd[k], exp_ba[k], exp_a[k]);
            end
            @(negedge clk);
        end
        tests++;
        if (bad != 0) fails++;
        // R3: ready is back the cycle after the column command, bus idle (R2 NOP)
        tests++;
        if (req_ready !== 1'b1 || bus_cmd() != 4'b0111) begin
            fails++;
            $display("FAIL R3 ready after column: rdy=%b cmd=%b expected rdy=1 cmd=0111",
                     req_ready, bus_cmd());
        end
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int trcd_set [6];
        trcd_set = '{1, 2, 3, 5, 0, 11};
        for (int b = 0; b < 8; b++) begin
            m_open[b] = 1'b0;
            m_row[b]  = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        tests++;
        if (req_ready !== 1'b1 || bus_cmd() != 4'b0111 || cmd_a != '0) begin
            fails++;
            $display("FAIL R10 reset: rdy=%b cmd=%b a=%h expected rdy=1 cmd=0111 a=0",
                     req_ready, bus_cmd(), cmd_a);
        end

        for (int t = 0; t < 6; t++) begin
            trcd_cycles = 5'(trcd_set[t]);
            for (int b = 0; b < 8; b++) begin
                logic [13:0] r1;
                logic [13:0] r2;
                r1 = 14'((b * 1237 + t * 311) & 16'h3fff);
                r2 = r1 ^ 14'h2a55;
                otf_en = (b % 2) == 0;
                // R1 R4 R5: closed bank, activate then column after the gap
                run_req((b % 3) == 0, b, r1, 10'(b * 97 + t), 1'b0, 1'b0, "R1 R4 R5 closed");
                // R6 R9: same row hit, chop on
                run_req(1'b1, b, r1, 10'h3ff - 10'(b), 1'b1, 1'b0, "R6 R9 hit");
                // R7: different row, precharge then activate
                run_req(1'b0, b, r2, 10'(t * 5), (t % 2) == 1, 1'b0, "R7 miss");
                // R8: auto precharge closes the bank
                run_req(1'b1, b, r2, 10'h155, 1'b0, 1'b1, "R8 autopre");
                run_req(1'b0, b, r2, 10'h2aa, 1'b1, 1'b0, "R8 reopen no precharge");
            end
            // R2: NOP while idle between requests
            @(negedge clk);
            tests++;
            if (bus_cmd() != 4'b0111) begin
                fails++;
                $display("FAIL R2 idle: cmd=%b expected 0111", bus_cmd());
            end
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule